// File: doc/BRIEF.md
# Parallel-Bus ADC Interface Emulator

This block stands in for the digital side of a 12-bit parallel-output converter, so that a host controller can be tested against it in simulation or on an FPGA. A falling edge on the conversion-start input captures a supplied 12-bit value and 2-bit channel number into a hold register. Busy then stays high while the block counts rising edges of a separate converter clock. On the thirteenth edge the held sample moves into the result register and busy drops. The converter clock is sampled on the system clock, so it may run continuously or arrive in bursts with arbitrary gaps.

The host reads the result over a 12-bit bus split into input, output and per-bit enable so it can be mapped to pads. Two layouts exist. In word mode the whole result appears at once. In byte mode bus bit 8 becomes the high-byte select and only the lower eight lines are driven. Low byte: result bits 7..0. High byte: result bits 11..8, then the channel number, then two zero bits. A 12-bit control register is written through the same bus on the rising edge of the write strobe, in one word or in two bytes. Its two lowest bits select a power mode. The two automatic modes put the block to sleep after each conversion, and a rising edge on conversion start wakes it.

Top module: `adc_par_emu`

## Requirements
- R1: With rst high at a rising clk edge, busy goes to 0 after that edge, the control register and the result register go to 0, and all bus enables are 0.
- R2: A falling edge of convst_n seen at a clk edge while idle and awake sets busy after that same edge and captures smp_val and smp_ch.
- R3: busy stays high until the thirteenth rising edge of mclk counted after the conversion began, whatever the gaps between mclk pulses. busy falls after the clk edge that sees that mclk edge, and the result register takes the captured value at the same edge and at no other time.
- R4: A falling edge of convst_n while busy is high has no effect: the count is not restarted and the new sample is not captured.
- R5: The bus enables are nonzero only while cs_n and rd_n are both 0.
- R6: In word mode (word_mode=1), a read drives all 12 lines with the result register (enable 0xFFF).
- R7: In byte mode with db_i[8]=0, a read drives db_o[7:0] with result bits 7..0; enables are 0x0FF, so lines 11..8 stay undriven.
- R8: In byte mode with db_i[8]=1, a read drives result bits 11..8 on db_o[3:0], the channel number on db_o[5:4], and 0 on db_o[7:6] (enables 0x0FF).
- R9: The control register is loaded only on a rising edge of wr_n seen while cs_n is 0. In word mode it takes db_i[11:0]. A strobe with cs_n high leaves it unchanged.
- R10: In byte mode a write with db_i[8]=0 loads control bits 7..0 from db_i[7:0]. A write with db_i[8]=1 loads control bits 11..8 from db_i[3:0], but only when db_i[7:4] is 0; otherwise it is discarded.
- R11: Control bits 1..0 select the power mode. 00 and 01 keep the block awake. 10 (auto-shutdown) and 11 (auto-standby) put it to sleep when a conversion ends. While asleep a convst_n falling edge is ignored, and a convst_n rising edge wakes the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| convst_n | input | 1 | Conversion start: falling edge starts, rising edge wakes |
| mclk | input | 1 | Converter clock, continuous or burst |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, captured on its rising edge |
| word_mode | input | 1 | 1 selects word transfers, 0 byte transfers |
| smp_val | input | 12 | Value to be "converted" |
| smp_ch | input | 2 | Channel number tagged to the value |
| db_i | input | 12 | Bus lines as seen from the pads; bit 8 is the high-byte select in byte mode |
| db_o | output | 12 | Bus output data |
| db_oe | output | 12 | Per-line output enable |
| busy | output | 1 | High during a conversion |
| ctrl_q | output | 12 | Current control register contents |

## Verification
The checker watches the bus on every cycle. It confirms that no line is enabled without both strobes, that the upper lines are never driven in byte mode, that busy only rises after a sampled convst_n fall, that busy only falls on a sampled mclk rise, that the result register changes only when busy falls, and that the control register changes only after a selected write strobe. The bench scenarios cover the exact thirteen-edge count under continuous and gapped converter clocks, the discarded start during busy, the value and channel placement in each read layout, byte-wise assembly including the rejected high byte, and the sleep and wake sequence of the automatic power modes.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int RES_W      = 12;
    localparam int CH_W       = 2;
    localparam int BUS_W      = 12;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int HSEL_BIT   = 8;
    localparam int CONV_EDGES = 13;

    typedef enum logic [1:0] {
        PM_RUN       = 2'b00,
        PM_RUN_ALT   = 2'b01,
        PM_AUTO_OFF  = 2'b10,
        PM_AUTO_STBY = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2
    } conv_st_e;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] val;
    } sample_t;

    typedef struct packed {
        logic [BUS_W-1:0] dat;
        logic [BUS_W-1:0] oe;
    } bus_drv_t;

    localparam logic [BUS_W-1:0] OE_WORD = {BUS_W{1'b1}};
    localparam logic [BUS_W-1:0] OE_BYTE = BUS_W'({BYTE_W{1'b1}});

    function automatic logic pm_sleeps(input logic [1:0] pm);
        return (pm == PM_AUTO_OFF) || (pm == PM_AUTO_STBY);
    endfunction

    function automatic bus_drv_t lay_word(input sample_t s);
        bus_drv_t d;
        d.dat = BUS_W'(s.val);
        d.oe  = OE_WORD;
        return d;
    endfunction

    function automatic bus_drv_t lay_low(input sample_t s);
        bus_drv_t d;
        d.dat = BUS_W'(s.val[BYTE_W-1:0]);
        d.oe  = OE_BYTE;
        return d;
    endfunction

    // upper nibble, channel tag above it, zero padding to the byte edge
    function automatic bus_drv_t lay_high(input sample_t s);
        bus_drv_t d;
        logic [BYTE_W-1:0] b;
        b = '0;
        b[NIB_W-1:0]           = s.val[RES_W-1:BYTE_W];
        b[NIB_W+CH_W-1:NIB_W]  = s.ch;
        d.dat = BUS_W'(b);
        d.oe  = OE_BYTE;
        return d;
    endfunction

endpackage

// File: rtl/adcif_edge.sv
module adcif_edge (
    input  logic clk,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic q;

    // follows the pin during reset too, so leaving reset never shows a false edge
    always_ff @(posedge clk) begin
        q <= d;
    end

    assign rise = d & ~q;
    assign fall = ~d & q;
endmodule

// File: rtl/adcif_conv_seq.sv
module adcif_conv_seq
    import adcif_pkg::*;
#(
    parameter int EDGES = CONV_EDGES,
    localparam int CNT_W = $clog2(EDGES + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_fall,
    input  logic    wake_rise,
    input  logic    mclk_rise,
    input  logic    auto_sleep,
    input  sample_t smp,
    output logic    busy,
    output sample_t res
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    conv_st_e         st;
    logic [CNT_W-1:0] cnt;
    sample_t          hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_TRACK;
            cnt  <= '0;
            hold <= '0;
            res  <= '0;
        end else begin
            unique case (st)
                ST_TRACK: begin
                    if (start_fall) begin
                        hold <= smp;
                        cnt  <= '0;
                        st   <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (mclk_rise) begin
                        if (cnt == LAST) begin
                            res <= hold;
                            st  <= auto_sleep ? ST_SLEEP : ST_TRACK;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (wake_rise) st <= ST_TRACK;
                end
                default: st <= ST_TRACK;
            endcase
        end
    end

    assign busy = (st == ST_CONV);
endmodule

// File: rtl/adcif_ctrl_reg.sv
module adcif_ctrl_reg
    import adcif_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_rise,
    input  logic         cs_n,
    input  logic         word_mode,
    input  logic [W-1:0] db_i,
    output logic [W-1:0] ctrl_q
);
    logic hsel;
    logic hi_clean;

    assign hsel     = db_i[HSEL_BIT];
    assign hi_clean = (db_i[BYTE_W-1:NIB_W] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_rise && !cs_n) begin
            if (word_mode) begin
                ctrl_q <= db_i;
            end else if (!hsel) begin
                ctrl_q[BYTE_W-1:0] <= db_i[BYTE_W-1:0];
            end else if (hi_clean) begin
                ctrl_q[W-1:BYTE_W] <= db_i[W-BYTE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/adcif_rd_mux.sv
module adcif_rd_mux
    import adcif_pkg::*;
(
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             word_mode,
    input  logic             hsel,
    input  sample_t          res,
    output logic [BUS_W-1:0] db_o,
    output logic [BUS_W-1:0] db_oe
);
    bus_drv_t drv;

    always_comb begin
        drv = '0;
        if (!cs_n && !rd_n) begin
            if (word_mode)  drv = lay_word(res);
            else if (hsel)  drv = lay_high(res);
            else            drv = lay_low(res);
        end
    end

    assign db_o  = drv.dat;
    assign db_oe = drv.oe;
endmodule

// File: rtl/adc_par_emu.sv
module adc_par_emu
    import adcif_pkg::*;
#(
    parameter int EDGES = CONV_EDGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             convst_n,
    input  logic             mclk,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             word_mode,
    input  logic [RES_W-1:0] smp_val,
    input  logic [CH_W-1:0]  smp_ch,
    input  logic [BUS_W-1:0] db_i,
    output logic [BUS_W-1:0] db_o,
    output logic [BUS_W-1:0] db_oe,
    output logic             busy,
    output logic [BUS_W-1:0] ctrl_q
);
    logic    cv_rise, cv_fall;
    logic    mk_rise, mk_fall;
    logic    wr_rise, wr_fall;
    sample_t smp;
    sample_t res_q;
    logic    auto_sleep;

    adcif_edge u_cv_edge (.clk(clk), .d(convst_n), .rise(cv_rise), .fall(cv_fall));
    adcif_edge u_mk_edge (.clk(clk), .d(mclk),     .rise(mk_rise), .fall(mk_fall));
    adcif_edge u_wr_edge (.clk(clk), .d(wr_n),     .rise(wr_rise), .fall(wr_fall));

    assign smp.val    = smp_val;
    assign smp.ch     = smp_ch;
    assign auto_sleep = pm_sleeps(ctrl_q[1:0]);

    adcif_conv_seq #(.EDGES(EDGES)) u_seq (
        .clk(clk), .rst(rst),
        .start_fall(cv_fall), .wake_rise(cv_rise), .mclk_rise(mk_rise),
        .auto_sleep(auto_sleep), .smp(smp),
        .busy(busy), .res(res_q)
    );

    adcif_ctrl_reg #(.W(BUS_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_rise(wr_rise), .cs_n(cs_n),
        .word_mode(word_mode), .db_i(db_i), .ctrl_q(ctrl_q)
    );

    adcif_rd_mux u_mux (
        .cs_n(cs_n), .rd_n(rd_n), .word_mode(word_mode),
        .hsel(db_i[HSEL_BIT]), .res(res_q),
        .db_o(db_o), .db_oe(db_oe)
    );

    logic unused_edges;
    assign unused_edges = mk_fall | wr_fall;
endmodule

// File: rtl/adc_par_emu_chk.sv
module adc_par_emu_chk
    import adcif_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             convst_n,
    input logic             mclk,
    input logic             cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             word_mode,
    input logic [BUS_W-1:0] db_oe,
    input logic             busy,
    input logic [BUS_W-1:0] ctrl_q,
    input sample_t          res_q
);
    assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (db_oe == '0));

    assert_upper_float_R7: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> (db_oe[BUS_W-1:BYTE_W] == '0));

    assert_busy_after_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(convst_n, 2) && !$past(convst_n)));

    assert_busy_ends_on_mclk_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(mclk) && !$past(mclk, 2)));

    assert_result_only_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_q) |-> $fell(busy));

    assert_ctrl_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> ($past(!cs_n) && $past(wr_n) && !$past(wr_n, 2)));
endmodule

bind adc_par_emu adc_par_emu_chk u_chk (
    .clk(clk), .rst(rst), .convst_n(convst_n), .mclk(mclk),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .word_mode(word_mode),
    .db_oe(db_oe), .busy(busy), .ctrl_q(ctrl_q), .res_q(res_q)
);

// File: tb/sim_adc_par_emu.sv
module sim_adc_par_emu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        convst_n = 1'b1;
    logic        mclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        word_mode = 1'b1;
    logic [11:0] smp_val = '0;
    logic [1:0]  smp_ch = '0;
    logic [11:0] db_i = '0;
    logic [11:0] db_o, db_oe, ctrl_q;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc_par_emu u0 (
        .clk(clk), .rst(rst), .convst_n(convst_n), .mclk(mclk),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .word_mode(word_mode),
        .smp_val(smp_val), .smp_ch(smp_ch), .db_i(db_i),
        .db_o(db_o), .db_oe(db_oe), .busy(busy), .ctrl_q(ctrl_q)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic mpulse();
        mclk = 1'b1; tick();
        mclk = 1'b0; tick();
    endtask

    task automatic start_conv(input logic [11:0] v, input logic [1:0] c);
        smp_val = v; smp_ch = c;
        convst_n = 1'b0; tick();
        convst_n = 1'b1; tick();
    endtask

    // drives a read and returns enabled data and enables
    task automatic bus_read(input logic wm, input logic hs,
                            output logic [11:0] d, output logic [11:0] e);
        word_mode = wm; db_i = '0; db_i[8] = hs;
        cs_n = 1'b0; rd_n = 1'b0; #1;
        d = db_o & db_oe; e = db_oe;
        cs_n = 1'b1; rd_n = 1'b1; word_mode = 1'b1; db_i = '0; #1;
    endtask

    task automatic bus_write(input logic wm, input logic sel, input logic [11:0] v);
        word_mode = wm; db_i = v; cs_n = sel ? 1'b0 : 1'b1;
        wr_n = 1'b0; tick();
        wr_n = 1'b1; tick();
        cs_n = 1'b1; word_mode = 1'b1; db_i = '0;
    endtask

    task automatic t_reset();
        logic [11:0] d, e;
        rst = 1'b1; idle(3);
        rst = 1'b0; tick();
        chk("R1 busy after reset", busy, 0);
        chk("R1 ctrl after reset", ctrl_q, 0);
        chk("R1 bus idle after reset", db_oe, 0);
        bus_read(1'b1, 1'b0, d, e);
        chk("R1 result after reset", d, 12'h000);
    endtask

    task automatic t_conv_cont();
        logic [11:0] d, e;
        smp_val = 12'hA5C; smp_ch = 2'd2;
        convst_n = 1'b0; tick();
        chk("R2 busy right after fall", busy, 1);
        convst_n = 1'b1; tick();
        for (int i = 0; i < 12; i++) mpulse();
        chk("R3 busy after 12 edges", busy, 1);
        bus_read(1'b1, 1'b0, d, e);
        chk("R3 result not yet updated", d, 12'h000);
        mclk = 1'b1; tick();
        chk("R3 busy falls on 13th edge", busy, 0);
        mclk = 1'b0; tick();
        bus_read(1'b1, 1'b0, d, e);
        chk("R2 captured value", d, 12'hA5C);
    endtask

    task automatic t_conv_burst();
        start_conv(12'h3C7, 2'd1);
        for (int i = 0; i < 12; i++) begin
            mpulse();
            idle((i % 4) * 5);
        end
        idle(40);
        chk("R3 busy held across burst gaps", busy, 1);
        mclk = 1'b1; tick();
        chk("R3 busy falls on 13th burst edge", busy, 0);
        mclk = 1'b0; tick();
    endtask

    task automatic t_reads();
        logic [11:0] d, e;
        bus_read(1'b1, 1'b0, d, e);
        chk("R6 word data", d, 12'h3C7);
        chk("R6 word enables", e, 12'hFFF);
        bus_read(1'b0, 1'b0, d, e);
        chk("R7 low byte data", d, 12'h0C7);
        chk("R7 low byte enables", e, 12'h0FF);
        bus_read(1'b0, 1'b1, d, e);
        chk("R8 high byte data", d, 12'h013);
        chk("R8 high byte enables", e, 12'h0FF);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R5 no drive with rd_n high", db_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R5 no drive with cs_n high", db_oe, 0);
        rd_n = 1'b1; #1;
    endtask

    task automatic t_ignore();
        logic [11:0] d, e;
        start_conv(12'h111, 2'd0);
        for (int i = 0; i < 5; i++) mpulse();
        start_conv(12'hEEE, 2'd3);
        chk("R4 still busy after second fall", busy, 1);
        for (int i = 0; i < 7; i++) mpulse();
        chk("R4 busy after 12 original edges", busy, 1);
        mclk = 1'b1; tick();
        chk("R4 count not restarted", busy, 0);
        mclk = 1'b0; tick();
        bus_read(1'b1, 1'b0, d, e);
        chk("R4 first sample kept", d, 12'h111);
        bus_read(1'b0, 1'b1, d, e);
        chk("R4 first channel kept", d, 12'h001);
    endtask

    task automatic t_ctrl_word();
        bus_write(1'b1, 1'b1, 12'hABC);
        chk("R9 word write", ctrl_q, 12'hABC);
        bus_write(1'b1, 1'b0, 12'h123);
        chk("R9 strobe without select ignored", ctrl_q, 12'hABC);
    endtask

    task automatic t_ctrl_byte();
        bus_write(1'b0, 1'b1, 12'h034);
        chk("R10 low byte write", ctrl_q, 12'hA34);
        bus_write(1'b0, 1'b1, 12'h105);
        chk("R10 high byte write", ctrl_q, 12'h534);
        bus_write(1'b0, 1'b1, 12'h1F7);
        chk("R10 high byte with nonzero top bits dropped", ctrl_q, 12'h534);
    endtask

    task automatic t_power();
        logic [11:0] d, e;
        bus_write(1'b1, 1'b1, 12'h002);
        start_conv(12'h2B4, 2'd1);
        for (int i = 0; i < 13; i++) mpulse();
        chk("R11 conversion done before sleep", busy, 0);
        convst_n = 1'b0; idle(2);
        chk("R11 fall ignored while asleep", busy, 0);
        convst_n = 1'b1; tick();
        start_conv(12'h777, 2'd2);
        chk("R11 awake after rising edge", busy, 1);
        for (int i = 0; i < 13; i++) mpulse();
        bus_read(1'b1, 1'b0, d, e);
        chk("R11 result after wake", d, 12'h777);
        bus_write(1'b1, 1'b1, 12'h001);
        convst_n = 1'b0; tick(); convst_n = 1'b1; tick();
        start_conv(12'h0F0, 2'd0);
        for (int i = 0; i < 13; i++) mpulse();
        start_conv(12'h0F1, 2'd0);
        chk("R11 mode 01 stays awake", busy, 1);
        for (int i = 0; i < 13; i++) mpulse();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_conv_cont();
        t_conv_burst();
        t_reads();
        t_ignore();
        t_ctrl_word();
        t_ctrl_byte();
        t_power();
        summary();
        $finish;
    end
endmodule